// File: doc/BRIEF.md
# CAN Receive Bit Sampler and Destuffer

This block turns one oversampled CAN receive line into the logical bit stream of a frame. While the bus is idle (recessive, logic 1) it watches for the first dominant (logic 0) sample. That clock edge becomes the timing reference for the whole frame. Every later raw bit is sampled at a fixed point inside its nominal bit period, counted from that one reference. No resynchronisation is applied on later edges.

Raw bits pass through a stuff filter. After five equal raw bits, the next raw bit is expected to be a stuff bit of the opposite level. It is removed from the output but kept in the run history. A sixth equal bit is reported as a stuff violation. Each bit that survives is presented downstream with a one-cycle valid strobe, its level and its destuffed frame index. The downstream frame parser drives two controls back. `tail_mode` turns stuff checking off from the CRC delimiter onward. `frame_end` ends the frame.

The output stream carries valid only, with no ready. The bus cannot be paused, so there is no back-pressure. The consumer must take every strobe in the cycle it appears. Strobes are at least `BIT_CYCLES` cycles apart. `rx_in` must already be synchronous to `clk`. `SAMPLE_PCT` must place the sample point strictly inside the bit, so that the offset is between 1 and `BIT_CYCLES-1`.

Top module: `can_bit_sampler`

## Requirements
- R1: While reset is held and right after it, `bit_valid`, `sof_err` and `stuff_err` are low, and `bit_value` and `bit_index` are zero.
- R2: In idle, recessive samples (1) produce no strobe and no error.
- R3: Let E0 be the first clock edge in idle that sees `rx_in`=0. Raw bit n (stuff bits included, SOF is n=0) is sampled at edge E0 + n*BIT_CYCLES + OFS, where OFS = BIT_CYCLES*SAMPLE_PCT/100 rounded down. Its outputs are registered at that same edge.
- R4: Each non-stuff raw bit gives a one-cycle `bit_valid` with `bit_value` equal to the sampled level. `bit_index` starts at 0 for the SOF bit and rises by one for each emitted bit.
- R5: When the previous five raw bits are equal and the new raw bit differs, the new bit is a stuff bit. It gets no strobe and does not advance `bit_index`. It then starts the next run of equal bits, so it counts towards the next stuff decision.
- R6: When the previous five raw bits are equal and the new raw bit matches them (with `tail_mode` low), `stuff_err` pulses for one cycle and `bit_valid` stays low. The block then returns to idle.
- R7: While `tail_mode` is high, no stuff check is made. Every raw bit is emitted and no `stuff_err` is raised.
- R8: If the SOF bit (index 0) is sampled recessive, it is emitted with `bit_value`=1 and `sof_err` high in the same cycle. The block then returns to idle.
- R9: `frame_end` high at a clock edge during a frame returns the block to idle at that edge. No strobe or error follows until a new dominant sample starts a frame, and the run history is cleared.
- R10: After MAX_RAW_BITS raw bits have been sampled in one frame, the block returns to idle.
- R11: Two `bit_valid` strobes are never on adjacent cycles, and `bit_valid` and `stuff_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Bus receive level, 0 dominant, 1 recessive |
| frame_end | input | 1 | From the parser: end the frame, return to idle |
| tail_mode | input | 1 | From the parser: stuff checking off (CRC delimiter onward) |
| bit_valid | output | 1 | One-cycle strobe for a destuffed bit |
| bit_value | output | 1 | Level of the destuffed bit |
| bit_index | output | $clog2(MAX_RAW_BITS) | Destuffed frame bit index, 0 = SOF |
| sof_err | output | 1 | SOF bit sampled recessive (with bit_valid) |
| stuff_err | output | 1 | Sixth equal raw bit where a stuff bit was due |

## Verification
The bench targets several corner cases, and names what a faulty design would show in each. A stuff bit must stay in the run history. A design that dropped it would miss the second stuff bit in a 00000-1-1111-0 sequence and emit an extra bit. The sample edge is checked cycle-exactly for every bit. This catches an off-by-one in the phase count or a point derived from the wrong edge, which would show as a shifted cycle. A sixth equal bit must raise an error only outside tail mode. Tail mode is exercised for both polarities, where a broken gate would raise `stuff_err` or swallow bits. A recessive SOF, a mid-frame `frame_end` and the raw-bit limit each check that the block goes quiet instead of carrying on emitting bits.

// File: rtl/can_smp_pkg.sv
package can_smp_pkg;

  // Number of equal raw bits after which a stuff bit is due.
  localparam int STUFF_RUN = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smp_state_e;

  typedef enum logic [1:0] {
    BK_DATA  = 2'd0,
    BK_STUFF = 2'd1,
    BK_VIOL  = 2'd2
  } bit_kind_e;

endpackage

// File: rtl/cs_phase_timer.sv
// Position inside the nominal bit period, counted from the SOF edge.
module cs_phase_timer #(
  parameter int BIT_CYCLES = 125,
  parameter int SAMPLE_OFS = 87
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic tick
);
  localparam int PH_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYCLES - 1);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_OFS);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (start) begin
      // the SOF edge is phase 0, so the next edge is phase 1
      phase <= PH_W'(1);
    end else if (run) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end else begin
      phase <= '0;
    end
  end

  assign tick = run && (phase == PH_SMP);

endmodule

// File: rtl/cs_stuff_tracker.sv
// Tracks the run of equal raw bits and classifies the next raw bit.
module cs_stuff_tracker
  import can_smp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      tick,
  input  logic      bit_in,
  input  logic      tail,
  output bit_kind_e kind
);
  localparam int RL_W = $clog2(STUFF_RUN + 1);
  localparam logic [RL_W-1:0] RL_FULL = RL_W'(STUFF_RUN);

  logic [RL_W-1:0] run_len;
  logic            prev_bit;

  always_comb begin
    kind = BK_DATA;
    if (!tail && run_len == RL_FULL) begin
      kind = (bit_in != prev_bit) ? BK_STUFF : BK_VIOL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_len  <= '0;
      prev_bit <= 1'b1;
    end else if (tick) begin
      if (run_len == '0 || bit_in != prev_bit) begin
        run_len  <= RL_W'(1);
        prev_bit <= bit_in;
      end else if (run_len != RL_FULL) begin
        run_len <= run_len + 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_smp_pkg::*;
#(
  parameter int BIT_CYCLES   = 125,
  parameter int SAMPLE_PCT   = 70,
  parameter int MAX_RAW_BITS = 160
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rx_in,
  input  logic                            frame_end,
  input  logic                            tail_mode,
  output logic                            bit_valid,
  output logic                            bit_value,
  output logic [$clog2(MAX_RAW_BITS)-1:0] bit_index,
  output logic                            sof_err,
  output logic                            stuff_err
);
  localparam int SAMPLE_OFS = (BIT_CYCLES * SAMPLE_PCT) / 100;
  localparam int IDX_W      = $clog2(MAX_RAW_BITS);
  localparam logic [IDX_W-1:0] RAW_LAST = IDX_W'(MAX_RAW_BITS - 1);

  smp_state_e       state;
  logic [IDX_W-1:0] raw_cnt;
  logic [IDX_W-1:0] idx;
  logic             start;
  logic             running;
  logic             tick;
  bit_kind_e        kind;

  assign start   = (state == ST_IDLE) && !rx_in;
  assign running = (state == ST_RUN);

  cs_phase_timer #(
    .BIT_CYCLES (BIT_CYCLES),
    .SAMPLE_OFS (SAMPLE_OFS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .run   (running),
    .tick  (tick)
  );

  cs_stuff_tracker u_stuff (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start || frame_end),
    .tick   (tick),
    .bit_in (rx_in),
    .tail   (tail_mode),
    .kind   (kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      raw_cnt   <= '0;
      idx       <= '0;
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
      bit_index <= '0;
      sof_err   <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      sof_err   <= 1'b0;
      stuff_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!rx_in) begin
            state   <= ST_RUN;
            raw_cnt <= '0;
            idx     <= '0;
          end
        end
        default: begin
          if (frame_end) begin
            state <= ST_IDLE;
          end else if (tick) begin
            raw_cnt <= raw_cnt + 1'b1;
            if (raw_cnt == RAW_LAST) begin
              state <= ST_IDLE;
            end
            case (kind)
              BK_VIOL: begin
                stuff_err <= 1'b1;
                state     <= ST_IDLE;
              end
              BK_STUFF: begin
                // dropped: no strobe, index unchanged
              end
              default: begin
                bit_valid <= 1'b1;
                bit_value <= rx_in;
                bit_index <= idx;
                idx       <= idx + 1'b1;
                if (idx == '0 && rx_in) begin
                  sof_err <= 1'b1;
                  state   <= ST_IDLE;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/can_bit_sampler_chk.sv
module can_bit_sampler_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_end,
  input logic             bit_valid,
  input logic             bit_value,
  input logic [IDX_W-1:0] bit_index,
  input logic             sof_err,
  input logic             stuff_err
);
  logic             seen;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      last_idx <= '0;
    end else if (bit_valid) begin
      seen     <= 1'b1;
      last_idx <= bit_index;
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && stuff_err));

  // R11
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R8
  sof_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_err |-> (bit_valid && bit_value && bit_index == '0));

  // R4
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_index != '0) |-> (seen && bit_index == last_idx + 1'b1));

  // R9
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!bit_valid && !stuff_err));

endmodule

bind can_bit_sampler can_bit_sampler_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .bit_valid (bit_valid),
  .bit_value (bit_value),
  .bit_index (bit_index),
  .sof_err   (sof_err),
  .stuff_err (stuff_err)
);

// File: tb/can_bit_sampler_test.sv
module can_bit_sampler_test;
  localparam int TB_BIT = 10;
  localparam int TB_PCT = 70;
  localparam int TB_OFS = (TB_BIT * TB_PCT) / 100;
  localparam int TB_MAX = 40;
  localparam int TB_IDX_W = $clog2(TB_MAX);
  localparam int NONE = 99;

  typedef struct packed {
    logic [63:0] raw;    // bit i = raw bit i, SOF at bit 0
    logic [63:0] smask;  // expected stuff positions
    int          len;
    int          fe_at;
    int          err_at;
    int          tail_from;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{64'h39A, 64'h0, 10, 10, NONE, NONE},            // plain, no stuffing
    '{64'h1A0, 64'h20, 9, 9, NONE, NONE},             // stuff after five zeros
    '{64'hBE0, 64'h420, 12, 12, NONE, NONE},          // stuff bit starts next run
    '{64'h7E, 64'h0, 7, 7, 6, NONE},                  // sixth equal bit
    '{64'hFE, 64'h0, 8, 8, NONE, 6},                  // tail mode, ones
    '{64'h80, 64'h0, 8, 8, NONE, 5},                  // tail mode, zeros
    '{64'h1A, 64'h0, 6, 4, NONE, NONE},               // frame_end mid frame
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 40, 42, NONE, NONE} // raw bit limit
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic frame_end = 1'b0;
  logic tail_mode = 1'b0;
  logic bit_valid, bit_value, sof_err, stuff_err;
  logic [TB_IDX_W-1:0] bit_index;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  int got_n = 0;
  int err_n = 0;
  int err_cyc = 0;
  int got_val [64];
  int got_idx [64];
  int got_sof [64];
  int got_cyc [64];

  always #4 clk = ~clk;

  can_bit_sampler #(
    .BIT_CYCLES   (TB_BIT),
    .SAMPLE_PCT   (TB_PCT),
    .MAX_RAW_BITS (TB_MAX)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_in),
    .frame_end (frame_end),
    .tail_mode (tail_mode),
    .bit_valid (bit_valid),
    .bit_value (bit_value),
    .bit_index (bit_index),
    .sof_err   (sof_err),
    .stuff_err (stuff_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (bit_valid && got_n < 64) begin
        got_val[got_n] = int'(bit_value);
        got_idx[got_n] = int'(bit_index);
        got_sof[got_n] = int'(sof_err);
        got_cyc[got_n] = cyc;
        got_n++;
      end
      if (stuff_err) begin
        err_n++;
        err_cyc = cyc;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      1, 2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6: return "R9";
      7: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic run_vec(input int v);
    vec_t cv;
    int e0;
    int stop;
    int k;
    cv = VECS[v];
    @(negedge clk);
    got_n = 0;
    err_n = 0;
    e0 = cyc + 1;
    for (int i = 0; i <= cv.fe_at; i++) begin
      rx_in = (i < cv.len && i < 64) ? cv.raw[i] : 1'b1;
      tail_mode = (i >= cv.tail_from);
      if (i == cv.fe_at) begin
        repeat (2) @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
      end else begin
        repeat (TB_BIT) @(negedge clk);
      end
    end
    rx_in = 1'b1;
    tail_mode = 1'b0;
    repeat (3 * TB_BIT) @(negedge clk);

    stop = cv.len;
    if (cv.fe_at < stop) stop = cv.fe_at;
    if (cv.err_at < stop) stop = cv.err_at;
    if (TB_MAX < stop) stop = TB_MAX;
    k = 0;
    for (int i = 0; i < stop; i++) begin
      if (!cv.smask[i]) begin
        if (k < got_n) begin
          chk(vtag(v), $sformatf("vec %0d bit %0d value (R4)", v, k), got_val[k], int'(cv.raw[i]));
          chk("R4", $sformatf("vec %0d bit %0d index", v, k), got_idx[k], k);
          chk("R3", $sformatf("vec %0d bit %0d sample cycle", v, k), got_cyc[k], e0 + i * TB_BIT + TB_OFS);
          chk("R8", $sformatf("vec %0d bit %0d sof flag", v, k), got_sof[k], 0);
        end
        k++;
      end
    end
    chk(vtag(v), $sformatf("vec %0d strobe count", v), got_n, k);
    if (cv.err_at < stop + 1 && cv.err_at == stop) begin
      chk("R6", $sformatf("vec %0d stuff_err count", v), err_n, 1);
      chk("R6", $sformatf("vec %0d stuff_err cycle", v), err_cyc, e0 + cv.err_at * TB_BIT + TB_OFS);
    end else begin
      chk(vtag(v), $sformatf("vec %0d no stuff_err (R6)", v), err_n, 0);
    end
  endtask

  initial begin
    int e0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "bit_valid in reset", int'(bit_valid), 0);
    chk("R1", "stuff_err in reset", int'(stuff_err), 0);
    chk("R1", "sof_err in reset", int'(sof_err), 0);
    chk("R1", "bit_index in reset", int'(bit_index), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bit_value after reset", int'(bit_value), 0);

    // R2: recessive idle bus
    got_n = 0;
    err_n = 0;
    repeat (5 * TB_BIT) @(negedge clk);
    chk("R2", "strobes on idle bus", got_n, 0);
    chk("R2", "errors on idle bus", err_n, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      run_vec(v);
    end

    // R8: short dominant glitch makes a recessive SOF sample
    @(negedge clk);
    got_n = 0;
    err_n = 0;
    e0 = cyc + 1;
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    rx_in = 1'b1;
    repeat (4 * TB_BIT) @(negedge clk);
    chk("R8", "glitch strobe count", got_n, 1);
    chk("R8", "glitch sof flag", got_sof[0], 1);
    chk("R8", "glitch bit value", got_val[0], 1);
    chk("R8", "glitch bit index", got_idx[0], 0);
    chk("R3", "glitch sample cycle", got_cyc[0], e0 + TB_OFS);

    // R9: a frame after the glitch starts cleanly at index 0
    run_vec(1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule